// File: doc/BRIEF.md
# Deferred Floating-Point Error Pin Generator

This block drives the active-low error pin that a processor's floating-point unit presents to external system logic. When retirement logic reports an unmasked floating-point exception, the block does not touch the pin. It only records that an error is pending. The pin is driven low later, at the boundary of the next instruction that touches the numeric state: a floating-point, SIMD-multimedia or WAIT instruction. The pin stays low until retirement reports one of the instructions that clear the error, or until reset.

The pin value comes straight from a flip-flop, so external logic may use the pin as a clock. A separate output enable lets the pad float the pin in three-state test mode. Every input is a plain, single-cycle strobe or level sampled on the rising clock edge. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

The numeric-error enable bit of the control register and the ignore-numeric-error input both reach the block, but neither has any effect on the pin.

Top module: `fp_err_pin`

## Requirements
- R1: While `rst` is high, and after it falls, `err_n_o` is 1 and no error is pending. A qualifying boundary right after reset leaves the pin high.
- R2: An unmasked exception strobe (`fpu_exc_i`) on its own never drives `err_n_o` low.
- R3: With an error pending, a boundary strobe (`bnd_valid_i`) whose class code is 1 (floating point), 2 (SIMD multimedia) or 3 (WAIT) drives `err_n_o` to 0 after the next rising edge. Class code 0 (any other instruction) leaves the pin unchanged.
- R4: A qualifying boundary that arrives in the same cycle as the exception strobe belongs to the faulting instruction and does not assert the pin. The next qualifying boundary does assert it.
- R5: A `clr_all_i` strobe drives `err_n_o` to 1 after the next edge and discards the pending error. This strobe marks completion of clear-exceptions, initialize, save-state or store-environment.
- R6: A `clr_load_i` strobe marks completion of load-control-word, load-environment or restore-state. With `load_unmasked_i` = 0 it acts as R5. With `load_unmasked_i` = 1 the pin keeps its level and an error becomes pending.
- R7: `ne_ctl_i` and `ignore_err_i` have no effect on `err_n_o` in any cycle.
- R8: When a clear (R5, or R6 with `load_unmasked_i` = 0) falls in the same cycle as a qualifying boundary or an exception strobe, the clear wins. The pin is 1 afterwards and a later qualifying boundary does not assert it.
- R9: A new exception strobe while `err_n_o` is 0 keeps the pin at 0, with no high pulse.
- R10: While `test_float_i` is 1, `err_oe_o` is 0 and the pad floats. The error state keeps updating meanwhile, and `err_oe_o` returns to 1 when `test_float_i` falls.
- R11: `err_n_o` changes only at rising clock edges. An input change between edges does not move it until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high. The error is clear when it falls. |
| fpu_exc_i | input | 1 | Unmasked floating-point exception detected at retirement |
| bnd_valid_i | input | 1 | An instruction boundary occurs this cycle |
| bnd_class_i | input | CLS_W | Class of the instruction at the boundary: 0 other, 1 FP, 2 SIMD, 3 WAIT |
| clr_all_i | input | 1 | Clear-exceptions, initialize, save-state or store-environment has completed |
| clr_load_i | input | 1 | Load-control-word, load-environment or restore-state has completed |
| load_unmasked_i | input | 1 | The newly loaded status and control words leave an unmasked exception |
| ne_ctl_i | input | 1 | Numeric-error enable bit of the control register (ignored) |
| ignore_err_i | input | 1 | Ignore-numeric-error input (ignored) |
| test_float_i | input | 1 | Three-state test mode |
| err_n_o | output | 1 | Active-low error pin value, taken directly from a flop |
| err_oe_o | output | 1 | Pad output enable; 0 floats the pin |

## Verification
Two functions can land on the same rising edge: a clear (unconditional, or a load that leaves nothing unmasked) and a qualifying boundary or a fresh exception. The bench provokes this by asserting a clear strobe together with a boundary of class 1 while the pin is low. It also asserts a clear together with an exception while the pin is high. The result is judged in two steps: the pin must be high after that edge, and a lone qualifying boundary on the following cycle must still leave it high. That second step shows the pending record was discarded, not just the pin.

// File: rtl/fperr_pkg.sv
package fperr_pkg;
  localparam int CLS_W = 2;
  localparam int NUM_CLS = 1 << CLS_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER = 2'd0,
    CLS_FP    = 2'd1,
    CLS_SIMD  = 2'd2,
    CLS_WAIT  = 2'd3
  } ins_class_e;

  // Classes whose boundary may expose a pending error (bit n = class code n)
  localparam logic [NUM_CLS-1:0] QUAL_DEFAULT =
    (NUM_CLS'(1) << CLS_FP) | (NUM_CLS'(1) << CLS_SIMD) | (NUM_CLS'(1) << CLS_WAIT);
endpackage

// File: rtl/fperr_bnd_qual.sv
module fperr_bnd_qual #(
  parameter int CLS_W = 2,
  parameter int NUM_CLS = 1 << CLS_W,
  parameter logic [NUM_CLS-1:0] QUAL_MASK = '1
) (
  input  logic             bnd_valid_i,
  input  logic [CLS_W-1:0] bnd_class_i,
  output logic             qual_o
);
  logic [NUM_CLS-1:0] hit;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    if (QUAL_MASK[c]) begin : g_on
      assign hit[c] = (bnd_class_i == CLS_W'(c));
    end else begin : g_off
      assign hit[c] = 1'b0;
    end
  end

  assign qual_o = bnd_valid_i && (|hit);
endmodule

// File: rtl/fperr_clr_ctl.sv
module fperr_clr_ctl (
  input  logic clr_all_i,
  input  logic clr_load_i,
  input  logic load_unmasked_i,
  output logic clr_o,
  output logic mark_o
);
  // A load that leaves an unmasked exception re-arms the pending record
  assign clr_o  = clr_all_i || (clr_load_i && !load_unmasked_i);
  assign mark_o = clr_load_i && load_unmasked_i && !clr_all_i;
endmodule

// File: rtl/fperr_core.sv
module fperr_core (
  input  logic clk,
  input  logic rst,
  input  logic exc_i,
  input  logic qual_i,
  input  logic clr_i,
  input  logic mark_i,
  output logic err_q,
  output logic pend_q
);
  logic err_d, pend_d;

  always_comb begin
    err_d  = err_q;
    pend_d = pend_q;
    if (clr_i) begin
      err_d  = 1'b0;
      pend_d = 1'b0;
    end else begin
      // Boundary uses the record from earlier instructions only
      if (qual_i && pend_q) err_d = 1'b1;
      if (exc_i || mark_i) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end

  assert_rst_clear_R1: assert property (@(posedge clk)
    rst |=> (!err_q && !pend_q));

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(qual_i && pend_q));

  // R5 and R8: a clear empties both flops whatever else arrives
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!err_q && !pend_q));

  assert_hold_low_R9: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_i) |=> err_q);
endmodule

// File: rtl/fp_err_pin.sv
module fp_err_pin #(
  parameter int CLS_W = fperr_pkg::CLS_W,
  parameter int NUM_CLS = 1 << CLS_W,
  parameter logic [NUM_CLS-1:0] QUAL_MASK = NUM_CLS'(fperr_pkg::QUAL_DEFAULT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fpu_exc_i,
  input  logic             bnd_valid_i,
  input  logic [CLS_W-1:0] bnd_class_i,
  input  logic             clr_all_i,
  input  logic             clr_load_i,
  input  logic             load_unmasked_i,
  input  logic             ne_ctl_i,
  input  logic             ignore_err_i,
  input  logic             test_float_i,
  output logic             err_n_o,
  output logic             err_oe_o
);
  logic qual_w, clr_w, mark_w, err_q, pend_q;

  fperr_bnd_qual #(
    .CLS_W(CLS_W), .NUM_CLS(NUM_CLS), .QUAL_MASK(QUAL_MASK)
  ) i_qual (
    .bnd_valid_i(bnd_valid_i),
    .bnd_class_i(bnd_class_i),
    .qual_o     (qual_w)
  );

  fperr_clr_ctl i_clr (
    .clr_all_i      (clr_all_i),
    .clr_load_i     (clr_load_i),
    .load_unmasked_i(load_unmasked_i),
    .clr_o          (clr_w),
    .mark_o         (mark_w)
  );

  fperr_core i_core (
    .clk   (clk),
    .rst   (rst),
    .exc_i (fpu_exc_i),
    .qual_i(qual_w),
    .clr_i (clr_w),
    .mark_i(mark_w),
    .err_q (err_q),
    .pend_q(pend_q)
  );

  // Pin value is the inverted flop state; the pad inverts nothing else
  assign err_n_o  = !err_q;
  assign err_oe_o = !test_float_i;

  assert_ignored_inputs_R7: assert property (@(posedge clk) disable iff (rst)
    (qual_w && pend_q && !clr_w && (ne_ctl_i || ignore_err_i)) |=> !err_n_o);

  assert_pin_level_R11: assert property (@(posedge clk) disable iff (rst)
    (!fpu_exc_i && !bnd_valid_i && !clr_all_i && !clr_load_i) |=> $stable(err_n_o));
endmodule

// File: tb/test_fp_err_pin.sv
`timescale 1ns/1ps
module test_fp_err_pin;
  logic clk = 1'b0;
  logic rst, exc, bv, cu, cc, lu, ne, ig, hz;
  logic [1:0] cls;
  logic err_n, oe;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  fp_err_pin i_fp_err_pin (
    .clk(clk), .rst(rst), .fpu_exc_i(exc), .bnd_valid_i(bv), .bnd_class_i(cls),
    .clr_all_i(cu), .clr_load_i(cc), .load_unmasked_i(lu), .ne_ctl_i(ne),
    .ignore_err_i(ig), .test_float_i(hz), .err_n_o(err_n), .err_oe_o(oe)
  );

  typedef struct packed {
    logic rst, exc, bv; logic [1:0] cls;
    logic cu, cc, lu, ne, ig, hz, en, oe; logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  //                 rst exc bv cls cu cc lu ne ig hz en oe req
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,0,0,0,0,0,0,1,1, 1},  // R1 reset
    '{1,1,0,0,0,0,0,0,0,0,1,1, 1},  // R1 exception ignored in reset
    '{0,0,0,0,0,0,0,0,0,0,1,1, 1},
    '{0,0,1,1,0,0,0,0,0,0,1,1, 3},  // R3 nothing pending
    '{0,1,0,0,0,0,0,0,0,0,1,1, 2},  // R2 exception alone
    '{0,0,1,0,0,0,0,0,0,0,1,1, 3},  // R3 class 0 does not qualify
    '{0,0,0,0,0,0,0,0,0,0,1,1, 2},
    '{0,0,1,1,0,0,0,0,0,0,0,1, 3},  // R3 FP boundary asserts
    '{0,1,0,0,0,0,0,0,0,0,0,1, 9},  // R9 new exception, stays low
    '{0,0,0,0,0,0,0,0,0,0,0,1, 9},
    '{0,0,0,0,1,0,0,0,0,0,1,1, 5},  // R5 clear
    '{0,0,1,2,0,0,0,0,0,0,1,1, 5},  // R5 pending discarded
    '{0,1,0,0,0,0,0,0,0,0,1,1, 2},
    '{0,0,1,2,0,0,0,0,0,0,0,1, 3},  // R3 SIMD boundary asserts
    '{0,0,0,0,0,1,1,0,0,0,0,1, 6},  // R6 load leaves unmasked: holds
    '{0,0,0,0,0,1,0,0,0,0,1,1, 6},  // R6 load clears
    '{0,0,1,3,0,0,0,0,0,0,1,1, 6},  // R6 pending discarded
    '{0,1,1,3,0,0,0,0,0,0,1,1, 4},  // R4 faulting instruction's own boundary
    '{0,0,1,3,0,0,0,0,0,0,0,1, 4},  // R4 next WAIT boundary asserts
    '{0,0,1,1,1,0,0,0,0,0,1,1, 8},  // R8 clear beats boundary
    '{0,0,1,1,0,0,0,0,0,0,1,1, 8},  // R8 no reassert
    '{0,1,0,0,0,0,0,1,1,0,1,1, 7},  // R7
    '{0,0,1,1,0,0,0,1,1,0,0,1, 7},  // R7 assert despite ignore/ne
    '{0,0,0,0,0,0,0,0,0,1,0,0,10},  // R10 floated
    '{0,0,0,0,1,0,0,0,0,1,1,0,10},  // R10 state updates while floated
    '{0,0,0,0,0,0,0,0,0,0,1,1,10},  // R10 enable returns
    '{0,0,0,0,0,1,1,0,0,0,1,1, 6},  // R6 load marks pending
    '{0,0,1,1,0,0,0,0,0,0,0,1, 6},  // R6 boundary exposes it
    '{1,0,0,0,0,0,0,0,0,0,1,1, 1},  // R1 reset while asserted
    '{0,0,1,1,0,0,0,0,0,0,1,1, 1},  // R1 nothing pending after reset
    '{0,1,0,0,1,0,0,0,0,0,1,1, 8},  // R8 clear beats exception
    '{0,0,1,1,0,0,0,0,0,0,1,1, 8},
    '{0,0,1,2,0,0,0,1,0,0,1,1, 7}   // R7 ne alone asserts nothing
  };

  task automatic check(input logic act, input logic exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rst = v.rst; exc = v.exc; bv = v.bv; cls = v.cls; cu = v.cu;
    cc = v.cc; lu = v.lu; ne = v.ne; ig = v.ig; hz = v.hz;
  endtask

  task automatic idle();
    rst = 0; exc = 0; bv = 0; cls = 0; cu = 0; cc = 0; lu = 0; ne = 0; ig = 0; hz = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      check(err_n, VECS[i].en, int'(VECS[i].req), $sformatf("row %0d err_n", i));
      check(oe, VECS[i].oe, int'(VECS[i].req), $sformatf("row %0d oe", i));
    end

    // R11: mid-cycle input changes do not reach the pin before the edge
    idle(); exc = 1;
    @(posedge clk); @(negedge clk);
    idle(); bv = 1; cls = 1;
    #1 check(err_n, 1'b1, 11, "boundary before edge");
    @(posedge clk); @(negedge clk);
    check(err_n, 1'b0, 11, "boundary after edge");
    idle(); cu = 1;
    #1 check(err_n, 1'b0, 11, "clear before edge");
    @(posedge clk); @(negedge clk);
    check(err_n, 1'b1, 11, "clear after edge");

    // R9: exception every cycle while asserted never pulses the pin high
    idle(); exc = 1;
    @(posedge clk); @(negedge clk);
    bv = 1; cls = 3;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      #1 check(err_n, 1'b0, 9, "repeat exception mid-cycle");
      @(posedge clk); @(negedge clk);
      check(err_n, 1'b0, 9, "repeat exception after edge");
    end

    // R1: a reset pulse clears, and the following boundary stays high
    idle(); rst = 1;
    @(posedge clk); @(negedge clk);
    check(err_n, 1'b1, 1, "reset pulse");
    idle(); bv = 1; cls = 2;
    @(posedge clk); @(negedge clk);
    check(err_n, 1'b1, 1, "boundary after reset");
    idle();
    @(posedge clk); @(negedge clk);
    finish_run();
  end
endmodule